// File: doc/BRIEF.md
# Triggered Eight-Channel Frame Capture Buffer

The block records fixed-length bursts of samples from eight converter channels that are sampled together. An accepted trigger, from an external line or a software pulse, starts a capture. The block then stores one row per sample clock into an on-chip buffer. Each row holds the upper nine bits of every channel's 10-bit word, packed as four 18-bit bank words.

The buffer is a ring of equal frame slots. Each frame fills one slot as a contiguous run of rows. When a frame completes, a descriptor is pushed into a FIFO. The descriptor carries the slot index and a wrapping event number.

The host works the other side while capture continues. It reads any row and bank with one cycle of latency, inspects the oldest descriptor, and releases it to free that slot. A trigger is dropped, and a sticky overflow flag is set, in two cases: a frame is still being written, or every slot is waiting for release.

Top module: `frame_capture`

## Requirements
- R1: Bank word b (0 to 3) of a stored row holds bits 9:1 of channel 2b in its bits 8:0 and bits 9:1 of channel 2b+1 in its bits 17:9; channel c occupies bits 10c+9:10c of `adc_raw`.
- R2: An accepted trigger stores the next FRAME_LEN sample clocks, sample i at row slot*FRAME_LEN + i, where the trigger is the value present at the accepting edge and sample 0 is the value presented at the following edge.
- R3: On the edge that writes the last sample of a frame, a descriptor {slot, event} is pushed; `desc_valid` is high after that edge and the descriptor shows the oldest unreleased frame.
- R4: A trigger arriving while a frame is being written is dropped: the frame keeps its length, no extra descriptor appears, and `overflow` is set on the next edge and stays set until reset.
- R5: A trigger arriving while all SLOTS slots hold unreleased frames is dropped, sets `overflow`, and leaves every stored frame unchanged.
- R6: The event counter starts at 0 after reset, and each accepted trigger takes the current value and then advances it by one, modulo 2^EVT_W. Dropped triggers do not advance it.
- R7: Slots are allocated in ring order 0, 1, ..., SLOTS-1, 0, and so on. Descriptors leave in allocation order. `desc_release` frees the oldest slot and is ignored while `desc_valid` is low.
- R8: `rd_word` shows bank `rd_bank` of row `rd_row` one clock after they are presented, including while a capture is writing another slot.
- R9: After reset, `desc_valid` and `overflow` are low and no capture is in progress.
- R10: `sw_trig` starts a capture exactly as `ext_trig` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_raw | input | 80 | Eight 10-bit converter words, channel c at bits 10c+9:10c |
| ext_trig | input | 1 | External trigger, one-cycle pulse |
| sw_trig | input | 1 | Software trigger, one-cycle pulse |
| rd_row | input | log2(FRAME_LEN)+log2(SLOTS) | Host read row address |
| rd_bank | input | 2 | Host read bank select |
| rd_word | output | 18 | Host read data, one clock after the address |
| desc_valid | output | 1 | Descriptor FIFO holds at least one entry |
| desc_slot | output | log2(SLOTS) | Slot of the oldest descriptor |
| desc_event | output | EVT_W | Event number of the oldest descriptor |
| desc_release | input | 1 | Pop the oldest descriptor and free its slot |
| overflow | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The first pattern is a lone trigger with a sample pattern that differs per channel and per sample. It separates the bank and channel packing order, the row offset, and frame alignment errors of one cycle. A second trigger that lands in the middle of a frame shows whether a busy capture restarts, lengthens, or wrongly consumes an event number. Filling every slot and then triggering again tells a correct full-ring drop apart from an overwrite of the oldest frame. Releases given in order, plus one given with the FIFO empty, expose ring-order and pointer slips. A software-triggered frame captured while the previous slot is being read tells concurrent read and write apart from a read that is blocked or corrupted.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  localparam int CHANNELS = 8;
  localparam int ADC_W    = 10;
  localparam int SMP_W    = ADC_W - 1;
  localparam int BANKS    = CHANNELS / 2;
  localparam int BANK_W   = 2 * SMP_W;
  localparam int ROW_W    = BANKS * BANK_W;
  localparam int RAW_W    = CHANNELS * ADC_W;
  localparam int BSEL_W   = $clog2(BANKS);
endpackage

// File: rtl/fcap_packer.sv
module fcap_packer
  import fcap_pkg::*;
(
  input  logic [RAW_W-1:0] raw_i,
  output logic [ROW_W-1:0] row_o
);
  // Each channel drops its converter LSB; channel c lands at c*SMP_W,
  // so bank b = {ch 2b+1, ch 2b}.
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    assign row_o[ch*SMP_W +: SMP_W] = raw_i[ch*ADC_W + 1 +: SMP_W];
  end
endmodule

// File: rtl/fcap_seq.sv
module fcap_seq #(
  parameter int FRAME_LEN = 256,
  parameter int SLOTS     = 4,
  parameter int EVT_W     = 24,
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int USED_W   = SLOT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_i,
  input  logic                    free_i,
  output logic                    wr_en_o,
  output logic [SLOT_W+IDX_W-1:0] wr_row_o,
  output logic                    push_o,
  output logic [SLOT_W-1:0]       push_slot_o,
  output logic [EVT_W-1:0]        push_evt_o,
  output logic                    ovf_o
);
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SLOT_W-1:0] cap_slot_q, cap_slot_d, nxt_slot_q, nxt_slot_d;
  logic [EVT_W-1:0]  cap_evt_q, cap_evt_d, evt_q, evt_d;
  logic [USED_W-1:0] used_q, used_d;
  logic              ovf_q, ovf_d;
  logic              ring_full, accept, last, idx_en;

  always_comb begin
    ring_full  = (used_q == USED_W'(SLOTS));
    accept     = trig_i && !busy_q && !ring_full;
    last       = busy_q && (idx_q == IDX_W'(FRAME_LEN - 1));
    idx_en     = accept || busy_q;
    busy_d     = busy_q;
    idx_d      = idx_q;
    cap_slot_d = cap_slot_q;
    cap_evt_d  = cap_evt_q;
    nxt_slot_d = nxt_slot_q;
    evt_d      = evt_q;
    if (accept) begin
      busy_d     = 1'b1;
      idx_d      = '0;
      cap_slot_d = nxt_slot_q;
      cap_evt_d  = evt_q;
      nxt_slot_d = nxt_slot_q + 1'b1;
      evt_d      = evt_q + 1'b1;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
    unique case ({accept, free_i})
      2'b10:   used_d = used_q + 1'b1;
      2'b01:   used_d = used_q - 1'b1;
      default: used_d = used_q;
    endcase
    ovf_d = ovf_q || (trig_i && !accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      cap_slot_q <= '0;
      cap_evt_q  <= '0;
      nxt_slot_q <= '0;
      evt_q      <= '0;
      used_q     <= '0;
      ovf_q      <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (idx_en) idx_q <= idx_d;
      if (accept) begin
        cap_slot_q <= cap_slot_d;
        cap_evt_q  <= cap_evt_d;
        nxt_slot_q <= nxt_slot_d;
        evt_q      <= evt_d;
      end
      used_q <= used_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_en_o     = busy_q;
  assign wr_row_o    = {cap_slot_q, idx_q};
  assign push_o      = last;
  assign push_slot_o = cap_slot_q;
  assign push_evt_o  = cap_evt_q;
  assign ovf_o       = ovf_q;

  assert_drop_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_q) |=> ovf_q);
  assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_drop_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !busy_q && ring_full) |=> (ovf_q && $stable(evt_q) && !busy_q));
  assert_evt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_q == $past(evt_q) || evt_q == $past(evt_q) + 1'b1));
endmodule

// File: rtl/fcap_fifo.sv
module fcap_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 26,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  logic [W-1:0]  ent_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          full;

  always_comb begin
    full  = (cnt_q == (AW+1)'(DEPTH));
    wp_d  = push_i ? wp_q + 1'b1 : wp_q;
    rp_d  = pop_i  ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q;
    if (push_i && !pop_i)      cnt_d = cnt_q + 1'b1;
    else if (!push_i && pop_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) ent_q[wp_q] <= din_i;
  end

  assign valid_o = (cnt_q != '0);
  assign dout_o  = ent_q[rp_q];

  assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (!full || pop_i));
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> valid_o);
endmodule

// File: rtl/fcap_mem.sv
module fcap_mem
  import fcap_pkg::*;
#(
  parameter int ROWS = 1024,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [ROW_W-1:0]  wdata_i,
  input  logic [AW-1:0]     raddr_i,
  input  logic [BSEL_W-1:0] rbank_i,
  output logic [BANK_W-1:0] rdata_o
);
  logic [ROW_W-1:0]  row_q [ROWS];
  logic [BANK_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) row_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rd_q <= row_q[raddr_i][rbank_i*BANK_W +: BANK_W];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/frame_capture.sv
module frame_capture
  import fcap_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int SLOTS     = 4,
  parameter int EVT_W     = 24,
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int ROW_AW   = IDX_W + SLOT_W,
  localparam int ROWS     = FRAME_LEN * SLOTS,
  localparam int DESC_W   = SLOT_W + EVT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [79:0]       adc_raw,
  input  logic              ext_trig,
  input  logic              sw_trig,
  input  logic [ROW_AW-1:0] rd_row,
  input  logic [1:0]        rd_bank,
  output logic [17:0]       rd_word,
  output logic              desc_valid,
  output logic [SLOT_W-1:0] desc_slot,
  output logic [EVT_W-1:0]  desc_event,
  input  logic              desc_release,
  output logic              overflow
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ROW_W-1:0]  row_data;
  logic              wr_en, push, pop;
  logic [ROW_AW-1:0] wr_row;
  logic [SLOT_W-1:0] push_slot;
  logic [EVT_W-1:0]  push_evt;
  logic [DESC_W-1:0] desc_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pop = desc_release && desc_valid;

  fcap_packer u_packer (.raw_i(adc_raw), .row_o(row_data));

  fcap_seq #(.FRAME_LEN(FRAME_LEN), .SLOTS(SLOTS), .EVT_W(EVT_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .trig_i(ext_trig || sw_trig), .free_i(pop),
    .wr_en_o(wr_en), .wr_row_o(wr_row), .push_o(push),
    .push_slot_o(push_slot), .push_evt_o(push_evt), .ovf_o(overflow));

  fcap_fifo #(.DEPTH(SLOTS), .W(DESC_W)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .push_i(push), .din_i({push_slot, push_evt}),
    .pop_i(pop), .valid_o(desc_valid), .dout_o(desc_word));

  fcap_mem #(.ROWS(ROWS)) u_mem (
    .clk(clk), .we_i(wr_en), .waddr_i(wr_row), .wdata_i(row_data),
    .raddr_i(rd_row), .rbank_i(rd_bank), .rdata_o(rd_word));

  assign desc_slot  = desc_word[DESC_W-1 -: SLOT_W];
  assign desc_event = desc_word[EVT_W-1:0];
endmodule

// File: tb/frame_capture_bench.sv
module frame_capture_bench;
  localparam int FL = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [79:0] adc_raw;
  logic        ext_trig, sw_trig, desc_release;
  logic [9:0]  rd_row;
  logic [1:0]  rd_bank;
  logic [17:0] rd_word;
  logic        desc_valid, overflow;
  logic [1:0]  desc_slot;
  logic [23:0] desc_event;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_capture u_frame_capture (
    .clk(clk), .rst_n(rst_n), .adc_raw(adc_raw), .ext_trig(ext_trig),
    .sw_trig(sw_trig), .rd_row(rd_row), .rd_bank(rd_bank), .rd_word(rd_word),
    .desc_valid(desc_valid), .desc_slot(desc_slot), .desc_event(desc_event),
    .desc_release(desc_release), .overflow(overflow));

  function automatic logic [9:0] smp(int seed, int i, int c);
    return 10'(seed * 13 + i * 5 + c * 71 + i * c);
  endfunction

  function automatic logic [17:0] exp_word(int seed, int i, int b);
    logic [9:0] lo, hi;
    lo = smp(seed, i, 2 * b);
    hi = smp(seed, i, 2 * b + 1);
    return {hi[9:1], lo[9:1]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_trig = 0; sw_trig = 0; desc_release = 0;
    adc_raw = '0; rd_row = '0; rd_bank = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One frame; optional mid-frame trigger and mid-frame host read.
  task automatic capture(int seed, bit use_sw, int drop_at, int rd_at,
                         int rrow, int rbank, logic [17:0] rexp);
    @(negedge clk);
    if (use_sw) sw_trig = 1'b1; else ext_trig = 1'b1;
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      if (drop_at >= 0 && i == drop_at + 1)
        chk(overflow == 1'b1, "R4 overflow after busy trigger", 32'(overflow), 1);
      if (rd_at >= 0 && i == rd_at + 1)
        chk(rd_word == rexp, "R8 read during capture", 32'(rd_word), 32'(rexp));
      ext_trig = 1'b0; sw_trig = 1'b0;
      if (i == drop_at) ext_trig = 1'b1;
      if (i == rd_at) begin rd_row = 10'(rrow); rd_bank = 2'(rbank); end
      for (int c = 0; c < 8; c++) adc_raw[c*10 +: 10] = smp(seed, i, c);
    end
    @(negedge clk);
    ext_trig = 1'b0; adc_raw = '0;
  endtask

  task automatic check_row(int slot, int i, int seed, string req);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      rd_row = 10'(slot * FL + i); rd_bank = 2'(b);
      @(negedge clk);
      chk(rd_word == exp_word(seed, i, b), req, 32'(rd_word), 32'(exp_word(seed, i, b)));
    end
  endtask

  task automatic check_desc(int slot, int ev, string req);
    chk(desc_valid == 1'b1, req, 32'(desc_valid), 1);
    chk(desc_slot == 2'(slot), req, 32'(desc_slot), 32'(slot));
    chk(desc_event == 24'(ev), req, 32'(desc_event), 32'(ev));
  endtask

  task automatic release_one();
    @(negedge clk); desc_release = 1'b1;
    @(negedge clk); desc_release = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    chk(desc_valid == 1'b0, "R9 desc_valid after reset", 32'(desc_valid), 0);
    chk(overflow == 1'b0, "R9 overflow after reset", 32'(overflow), 0);
  endtask

  task automatic test_basic();
    do_reset();
    capture(3, 1'b0, -1, -1, 0, 0, '0);
    check_desc(0, 0, "R3 R6 first descriptor");
    chk(overflow == 1'b0, "R2 no overflow on single frame", 32'(overflow), 0);
    check_row(0, 0, 3, "R1 R2 row 0");
    check_row(0, 1, 3, "R1 R2 row 1");
    check_row(0, FL - 1, 3, "R2 last row");
  endtask

  task automatic test_busy_drop();
    do_reset();
    capture(5, 1'b0, 10, -1, 0, 0, '0);
    check_desc(0, 0, "R4 frame kept");
    check_row(0, FL - 1, 5, "R4 frame length unchanged");
    release_one();
    chk(desc_valid == 1'b0, "R4 no extra descriptor", 32'(desc_valid), 0);
    capture(6, 1'b0, -1, -1, 0, 0, '0);
    check_desc(1, 1, "R6 dropped trigger not counted");
    chk(overflow == 1'b1, "R4 overflow sticky", 32'(overflow), 1);
  endtask

  task automatic test_sw_concurrent();
    do_reset();
    capture(9, 1'b0, -1, -1, 0, 0, '0);
    capture(11, 1'b1, -1, 100, 5, 2, exp_word(9, 5, 2));
    check_desc(0, 0, "R10 head unchanged");
    release_one();
    check_desc(1, 1, "R10 software trigger frame");
    check_row(1, 0, 11, "R10 sw frame row 0");
    check_row(1, 128, 11, "R10 sw frame row 128");
  endtask

  task automatic test_ring();
    do_reset();
    for (int f = 0; f < 4; f++) capture(20 + f, 1'b0, -1, -1, 0, 0, '0);
    chk(overflow == 1'b0, "R5 no overflow before full", 32'(overflow), 0);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    chk(overflow == 1'b1, "R5 overflow when full", 32'(overflow), 1);
    repeat (FL + 4) @(negedge clk);
    check_row(0, 7, 20, "R5 oldest frame not overwritten");
    check_desc(0, 0, "R7 head slot 0");
    release_one();
    check_desc(1, 1, "R7 head after release");
    capture(30, 1'b0, -1, -1, 0, 0, '0);
    for (int k = 1; k < 4; k++) begin
      check_desc(k, k, "R7 ring order");
      release_one();
    end
    check_desc(0, 4, "R7 R6 wrapped slot");
    release_one();
    chk(desc_valid == 1'b0, "R7 fifo empty", 32'(desc_valid), 0);
    release_one();
    capture(31, 1'b0, -1, -1, 0, 0, '0);
    check_desc(1, 5, "R7 empty release ignored");
    check_row(0, 9, 30, "R7 slot 0 reused after release");
    check_row(1, 9, 31, "R7 slot 1 new frame");
  endtask

  initial begin
    test_reset();
    test_basic();
    test_busy_drop();
    test_sw_concurrent();
    test_ring();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule